// File: doc/BRIEF.md
# Sizable Base Address Register

One device-side base address register of a configuration header. It holds the decode base of a single window in either memory space or I/O space, and it answers the standard size probe. Software writes all ones, reads back a value whose cleared low bits give the window size, and then writes the real base. Storing a real base also turns on the matching response enable of the command register. The space and the low type bits come from a fixed type code input. The window size is a compile-time power of two, and a size of zero turns the register into plain storage. Matching transaction addresses against the base is left to the logic that uses `base_addr`.

The register tracks its own lifecycle in a small state machine. The states are `ST_BLANK` (out of reset, nothing written), `ST_PROBED` (only probe values written so far), `ST_MEM_MAPPED` and `ST_IO_MAPPED` (a real base has been stored). The transitions are:
- *probe*: `ST_BLANK` to `ST_PROBED`, on a probe write.
- *map*: `ST_BLANK` or `ST_PROBED` to a mapped state, on a real write. The target state is picked by type code bit 0.
- *reprobe*: a probe write in `ST_PROBED` stays in `ST_PROBED`.
- *hold*: a mapped state never leaves except through reset.

A zero-size register never leaves `ST_BLANK`.

Top module: `bar_sizing`

## Requirements
- R1: After reset, `rd_value`, `base_addr`, `mem_en` and `io_en` are all zero.
- R2: A write of 32'h0000_0000 or 32'hFFFF_FFFF is a probe. It leaves `base_addr`, `mem_en` and `io_en` unchanged.
- R3: With type code bit 0 = 0 (memory), any other written value stores `base_addr` = value with bits [3:0] cleared, and sets `mem_en`.
- R4: With type code bit 0 = 1 (I/O), any other written value stores `base_addr` = value with bits [1:0] cleared, and sets `io_en`.
- R5: Memory readback after any write is the written value with bits below max(WIN_LOG2,4) cleared, ORed with the 4-bit type code in bits [3:0].
- R6: I/O readback after any write is the written value with bits below max(WIN_LOG2,2) cleared, and bits [1:0] forced to 2'b01.
- R7: `mem_en` and `io_en` are sticky until reset. Only the enable of the register's own space is ever set.
- R8: With WIN_LOG2 = 0 the register is plain storage. Readback equals the written value, and `base_addr` and the enables stay zero.
- R9: Every write takes effect on the clock edge where `cfg_wr` is sampled high. Without a write, `rd_value` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe for this register |
| cfg_wdata | input | 32 | Configuration write data |
| type_code | input | 4 | Fixed type code; bit 0 = 1 selects I/O space |
| rd_value | output | 32 | Configuration readback value |
| base_addr | output | 32 | Stored decode base |
| mem_en | output | 1 | Command-register memory response enable |
| io_en | output | 1 | Command-register I/O response enable |

## Verification
The hardest situation to reach is a probe that arrives after a base has already been assigned. That write must change the readback to the size mask but leave the stored base and the sticky enable alone. Both outputs have already moved away from their reset values by then, so a faulty design that reloads the base would look correct from a clean start. The stimulus reaches this case by sweeping a walking-one and walking-zero pattern through all 32 bit positions for each space, and then writing both probe values on top of the last real base.

// File: rtl/bar_pkg.sv
package bar_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned TYPE_W = 4;

    typedef enum logic [1:0] {
        ST_BLANK      = 2'd0,
        ST_PROBED     = 2'd1,
        ST_MEM_MAPPED = 2'd2,
        ST_IO_MAPPED  = 2'd3
    } bar_state_e;

endpackage

// File: rtl/bar_probe_detect.sv
module bar_probe_detect
    import bar_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    output logic              is_probe
);
    logic all_zero;
    logic all_one;

    always_comb begin
        all_zero = (wdata == '0);
        all_one  = (wdata == '1);
        is_probe = all_zero | all_one;
    end
endmodule

// File: rtl/bar_readback_mask.sv
module bar_readback_mask
    import bar_pkg::*;
#(
    parameter int unsigned WIN_LOG2 = 8
)(
    input  logic              is_io,
    input  logic [TYPE_W-1:0] type_code,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rb_value,
    output logic [DATA_W-1:0] base_value
);
    localparam int unsigned MEM_LOG2 = (WIN_LOG2 < 4) ? 4 : WIN_LOG2;
    localparam int unsigned IO_LOG2  = (WIN_LOG2 < 2) ? 2 : WIN_LOG2;
    localparam logic [DATA_W-1:0] MEM_KEEP = ~((DATA_W'(1) << MEM_LOG2) - DATA_W'(1));
    localparam logic [DATA_W-1:0] IO_KEEP  = ~((DATA_W'(1) << IO_LOG2) - DATA_W'(1));
    localparam logic [DATA_W-1:0] MEM_BASE_KEEP = ~DATA_W'(32'hF);
    localparam logic [DATA_W-1:0] IO_BASE_KEEP  = ~DATA_W'(32'h3);

    always_comb begin
        base_value = is_io ? (wdata & IO_BASE_KEEP) : (wdata & MEM_BASE_KEEP);
    end

    generate
        if (WIN_LOG2 == 0) begin : g_plain
            always_comb begin
                rb_value = wdata;
            end
        end else begin : g_sized
            always_comb begin
                if (is_io) begin
                    rb_value = (wdata & IO_KEEP) | DATA_W'(1);
                end else begin
                    rb_value = (wdata & MEM_KEEP) | DATA_W'(type_code);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bar_life_fsm.sv
module bar_life_fsm
    import bar_pkg::*;
#(
    parameter bit SIZED = 1'b1
)(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic is_probe,
    input  logic is_io,
    output logic load_base,
    output logic mem_en,
    output logic io_en
);
    bar_state_e state_q;
    bar_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK, ST_PROBED: begin
                if (wr && SIZED) begin
                    if (is_probe) begin
                        state_d = ST_PROBED;
                    end else if (is_io) begin
                        state_d = ST_IO_MAPPED;
                    end else begin
                        state_d = ST_MEM_MAPPED;
                    end
                end
            end
            ST_MEM_MAPPED: state_d = ST_MEM_MAPPED;
            ST_IO_MAPPED:  state_d = ST_IO_MAPPED;
            default:       state_d = ST_BLANK;
        endcase
    end

    always_comb begin
        load_base = wr && SIZED && !is_probe;
        mem_en    = (state_q == ST_MEM_MAPPED);
        io_en     = (state_q == ST_IO_MAPPED);
    end
endmodule

// File: rtl/bar_sizing.sv
module bar_sizing
    import bar_pkg::*;
#(
    parameter int unsigned WIN_LOG2 = 8
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic [3:0]  type_code,
    output logic [31:0] rd_value,
    output logic [31:0] base_addr,
    output logic        mem_en,
    output logic        io_en
);
    localparam bit SIZED = (WIN_LOG2 != 0);

    logic              is_io;
    logic              is_probe;
    logic              load_base;
    logic [DATA_W-1:0] rb_next;
    logic [DATA_W-1:0] base_next;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] base_q;

    assign is_io = type_code[0];

    bar_probe_detect u_probe (
        .wdata    (cfg_wdata),
        .is_probe (is_probe)
    );

    bar_readback_mask #(.WIN_LOG2(WIN_LOG2)) u_mask (
        .is_io      (is_io),
        .type_code  (type_code),
        .wdata      (cfg_wdata),
        .rb_value   (rb_next),
        .base_value (base_next)
    );

    bar_life_fsm #(.SIZED(SIZED)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .is_probe  (is_probe),
        .is_io     (is_io),
        .load_base (load_base),
        .mem_en    (mem_en),
        .io_en     (io_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= '0;
            base_q <= '0;
        end else begin
            if (cfg_wr) begin
                rd_q <= rb_next;
            end
            if (load_base) begin
                base_q <= base_next;
            end
        end
    end

    assign rd_value  = rd_q;
    assign base_addr = base_q;
endmodule

// File: rtl/bar_sizing_checks.sv
module bar_sizing_checks #(
    parameter int unsigned WIN_LOG2 = 8
)(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [31:0] cfg_wdata,
    input logic [3:0]  type_code,
    input logic [31:0] rd_value,
    input logic [31:0] base_addr,
    input logic        mem_en,
    input logic        io_en
);
    localparam bit SIZED = (WIN_LOG2 != 0);

    logic probe_w;
    assign probe_w = (cfg_wdata == 32'h0) || (cfg_wdata == 32'hFFFF_FFFF);

    a_r2_probe_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && probe_w |=> $stable(base_addr) && $stable(mem_en) && $stable(io_en));

    a_r3_mem_assign: assert property (@(posedge clk) disable iff (!rst_n)
        SIZED && cfg_wr && !probe_w && !type_code[0]
        |=> mem_en && (base_addr == ($past(cfg_wdata) & 32'hFFFF_FFF0)));

    a_r4_io_assign: assert property (@(posedge clk) disable iff (!rst_n)
        SIZED && cfg_wr && !probe_w && type_code[0]
        |=> io_en && (base_addr == ($past(cfg_wdata) & 32'hFFFF_FFFC)));

    a_r6_io_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        SIZED && cfg_wr && type_code[0] |=> rd_value[1:0] == 2'b01);

    a_r7_mem_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> mem_en);

    a_r7_io_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |=> io_en);

    a_r7_one_space: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_en, io_en}) <= 1);

    a_r8_plain_store: assert property (@(posedge clk) disable iff (!rst_n)
        !SIZED && cfg_wr |=> rd_value == $past(cfg_wdata));

    a_r8_plain_no_base: assert property (@(posedge clk) disable iff (!rst_n)
        !SIZED |-> base_addr == 32'h0 && !mem_en && !io_en);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(rd_value));
endmodule

bind bar_sizing bar_sizing_checks #(.WIN_LOG2(WIN_LOG2)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .type_code (type_code),
    .rd_value  (rd_value),
    .base_addr (base_addr),
    .mem_en    (mem_en),
    .io_en     (io_en)
);

// File: tb/test_bar_sizing.sv
module test_bar_sizing;
    localparam int unsigned WL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  type_code = '0;
    logic [31:0] rd_value, base_addr;
    logic        mem_en, io_en;

    logic        p_wr = 1'b0;
    logic [31:0] p_wdata = '0;
    logic [31:0] p_rd, p_base;
    logic        p_mem, p_io;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_base;
    logic        exp_mem, exp_io;

    always #10 clk = ~clk;

    bar_sizing #(.WIN_LOG2(WL)) i_bar_sizing (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .type_code(type_code), .rd_value(rd_value), .base_addr(base_addr),
        .mem_en(mem_en), .io_en(io_en)
    );

    bar_sizing #(.WIN_LOG2(0)) i_bar_sizing_plain (
        .clk(clk), .rst_n(rst_n), .cfg_wr(p_wr), .cfg_wdata(p_wdata),
        .type_code(4'b0000), .rd_value(p_rd), .base_addr(p_base),
        .mem_en(p_mem), .io_en(p_io)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rb(input logic [31:0] d, input logic [3:0] t);
        logic [31:0] keep;
        if (t[0]) begin
            keep = ~((32'd1 << WL) - 32'd1);
            return (d & keep & 32'hFFFF_FFFC) | 32'h1;
        end
        keep = ~((32'd1 << WL) - 32'd1);
        return (d & keep & 32'hFFFF_FFF0) | {28'd0, t};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_base = '0; exp_mem = 1'b0; exp_io = 1'b0;
    endtask

    task automatic wr_main(input logic [31:0] d);
        logic probe;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        probe = (d == 32'h0) || (d == 32'hFFFF_FFFF);
        if (!probe) begin
            if (type_code[0]) begin
                exp_base = d & 32'hFFFF_FFFC; exp_io = 1'b1;
            end else begin
                exp_base = d & 32'hFFFF_FFF0; exp_mem = 1'b1;
            end
        end
        if (type_code[0]) begin
            chk("R6 io readback", rd_value, exp_rb(d, type_code));
            chk("R4 io base", base_addr, exp_base);
        end else begin
            chk("R5 mem readback", rd_value, exp_rb(d, type_code));
            chk("R3 mem base", base_addr, exp_base);
        end
        chk("R7 mem_en", {31'd0, mem_en}, {31'd0, exp_mem});
        chk("R7 io_en", {31'd0, io_en}, {31'd0, exp_io});
    endtask

    task automatic sweep();
        for (int k = 0; k < 32; k++) begin
            wr_main(32'd1 << k);
            wr_main(~(32'd1 << k));
        end
        wr_main(32'hA5C3_96E7);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        exp_base = '0; exp_mem = 1'b0; exp_io = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rd", rd_value, 32'h0);
        chk("R1 reset base", base_addr, 32'h0);
        chk("R1 reset enables", {30'd0, mem_en, io_en}, 32'h0);

        // memory space, prefetch-style type bits
        type_code = 4'b1000;
        wr_main(32'hFFFF_FFFF);
        chk("R2 probe keeps mem_en", {31'd0, mem_en}, 32'h0);
        chk("R5 probe mask", rd_value, 32'hFFFF_FF08);
        wr_main(32'h0);
        chk("R2 zero probe base", base_addr, 32'h0);
        sweep();
        wr_main(32'hFFFF_FFFF);
        chk("R2 probe after map base", base_addr, 32'hA5C3_96E0);
        wr_main(32'h0);
        chk("R2 zero after map base", base_addr, 32'hA5C3_96E0);
        repeat (5) @(negedge clk);
        chk("R9 hold", rd_value, 32'h8);

        // plain memory type
        do_reset();
        type_code = 4'b0000;
        sweep();

        // I/O space
        do_reset();
        chk("R1 reset again", base_addr, 32'h0);
        type_code = 4'b0001;
        wr_main(32'hFFFF_FFFF);
        chk("R6 io probe mask", rd_value, 32'hFFFF_FF01);
        sweep();
        wr_main(32'hFFFF_FFFF);
        chk("R2 io probe after map", base_addr, 32'hA5C3_96E4);
        chk("R7 only io", {31'd0, mem_en}, 32'h0);

        // zero-size register
        foreach (p_wdata[i]) begin end
        for (int k = 0; k < 34; k++) begin
            logic [31:0] d;
            d = (k == 32) ? 32'hFFFF_FFFF : (k == 33) ? 32'h0 : (32'h1357_9BDF ^ (32'd1 << k));
            @(negedge clk);
            p_wr = 1'b1; p_wdata = d;
            @(negedge clk);
            p_wr = 1'b0;
            chk("R8 plain readback", p_rd, d);
            chk("R8 plain base", p_base, 32'h0);
            chk("R8 plain enables", {30'd0, p_mem, p_io}, 32'h0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule